// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block sits beside a small 8-bit processor core. It collects interrupt events from a set of sources and keeps one pending flag per source. It decides which source the core should service next and hands the core the address of that source's handler. Each source has an enable bit and a priority bit. A single global enable gates every source at once. Pending flags are captured whether or not anything is enabled, so an event that arrives while interrupts are off is not lost.

The core tells the controller when an instruction finishes. The controller raises a call request only at that moment. It holds the request, with the handler address, until the core acknowledges it. Two nesting flags record whether a low-level handler, a high-level handler or both are running. A return from interrupt retires the higher one. Software reaches the flags, enables, priorities and global enable through a small register port. That port supports a plain write, a bit-set and a bit-clear. Setting a pending flag this way behaves just like a hardware event. A parameter mask picks which sources have their flag cleared by hardware when the call is taken. Software must clear the flags of all other sources.

Top module: `intc_two_level`

## Requirements
- R1: An event pulse on `src_evt[n]` sets pending flag n on the next clock edge. This happens whatever the state of the enable bits and the global enable.
- R2: `irq_pend` is high only when the global enable, the source's enable bit and its pending flag are all 1, and the nesting rules of R9 allow that source's level.
- R3: The global enable is bit 7 of the control register. While it is 0, no request is raised and pending flags keep their value. Once it returns to 1, those flags are serviced.
- R4: `irq_req` rises only in the cycle after a clock edge at which `cpu_insn_done` was high, `cpu_reti` was low and a request was eligible. It then holds steady, together with `irq_vec`, until the edge at which `irq_ack` is high.
- R5: `irq_vec` equals 0x0003 + 8·n for the granted source n.
- R6: At the acknowledge edge, the pending flag of the granted source is cleared if that source's bit in the hardware-clear mask is set. The default mask is 0x05, which covers sources 0 and 2. All other flags stay set.
- R7: If a flag is still eligible when `cpu_reti` is pulsed, `irq_pend` is high in the very next cycle. A `cpu_insn_done` that comes in the same cycle as `cpu_reti` does not dispatch. The request is raised at the next instruction boundary.
- R8: A register set or write of 1 to a pending flag raises a request exactly as a hardware event would.
- R9: A high-priority request (priority bit 1) may interrupt a running low-priority handler. A low-priority request interrupts no handler. No request interrupts a handler of its own level.
- R10: `cpu_reti` clears the high-level active flag if it is set. Otherwise it clears the low-level active flag.
- R11: Among eligible requests, any high-priority one beats any low-priority one. Within a level, the lowest source index wins.
- R12: If a hardware event and a software clear of the same pending flag fall in the same cycle, the flag ends up set.
- R13: `reg_sel` picks the register: 0 is pending, 1 is enable, 2 is priority, 3 is control. `reg_op` picks the operation: 0 writes, 1 sets the bits given in `reg_wdata`, 2 clears them, and 3 leaves the register unchanged. `reg_rdata` shows the selected register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_evt | input | N_SRC | One-cycle event pulses, one per source |
| reg_wr | input | 1 | Register access strobe |
| reg_sel | input | 2 | Register select |
| reg_op | input | 2 | Access operation: write, set or clear |
| reg_wdata | input | N_SRC | Write data or bit mask |
| reg_rdata | output | N_SRC | Contents of the selected register |
| cpu_insn_done | input | 1 | Current instruction has finished |
| cpu_reti | input | 1 | Return from interrupt has completed |
| irq_ack | input | 1 | Core takes the call this cycle |
| irq_req | output | 1 | Call request valid |
| irq_vec | output | VEC_W | Handler address for the request |
| irq_pend | output | 1 | An eligible request exists now |

## Verification
The main function is tried in several situations. One has a single source with enables off, then on. One has two sources at the same level, where index order alone decides. One pairs a low-indexed low-priority source with a high-indexed high-priority source, which shows that level ranks above index. Preemption is tried with one handler running at each level, which separates the three nesting cases: high over low, blocked low, and blocked same level. Returns are tried both with and without an instruction boundary in the same cycle. This shows whether the controller waits for the following instruction before it raises the request. Finally, some sources are cleared by hardware and some by software, and the same-cycle event/clear collision is driven, to tell the two clearing rules and the collision rule apart.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        SEL_PEND = 2'd0,
        SEL_EN   = 2'd1,
        SEL_PRIO = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } reg_op_e;
endpackage

// File: rtl/intc_pick.sv
module intc_pick #(
    parameter int N  = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan downward so the lowest set index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/intc_regbank.sv
module intc_regbank
    import intc_pkg::*;
#(
    parameter int N       = 8,
    parameter int GEN_BIT = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_evt,
    input  logic         reg_wr,
    input  logic [1:0]   reg_sel,
    input  logic [1:0]   reg_op,
    input  logic [N-1:0] reg_wdata,
    input  logic [N-1:0] hw_clr,
    output logic [N-1:0] reg_rdata,
    output logic [N-1:0] pend,
    output logic [N-1:0] en,
    output logic [N-1:0] prio,
    output logic         gen
);
    typedef struct packed {
        logic [N-1:0] pend;
        logic [N-1:0] en;
        logic [N-1:0] prio;
        logic         gen;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N-1:0] ctrl_cur, ctrl_new;

    function automatic logic [N-1:0] apply_op(input logic [N-1:0] cur,
                                              input logic [1:0] op,
                                              input logic [N-1:0] data);
        case (reg_op_e'(op))
            OP_WRITE: return data;
            OP_SET:   return cur | data;
            OP_CLEAR: return cur & ~data;
            default:  return cur;
        endcase
    endfunction

    always_comb begin
        bank_d = bank_q;
        ctrl_cur = '0;
        ctrl_cur[GEN_BIT] = bank_q.gen;
        ctrl_new = apply_op(ctrl_cur, reg_op, reg_wdata);
        if (reg_wr) begin
            case (reg_sel_e'(reg_sel))
                SEL_PEND: bank_d.pend = apply_op(bank_q.pend, reg_op, reg_wdata);
                SEL_EN:   bank_d.en   = apply_op(bank_q.en, reg_op, reg_wdata);
                SEL_PRIO: bank_d.prio = apply_op(bank_q.prio, reg_op, reg_wdata);
                default:  bank_d.gen  = ctrl_new[GEN_BIT];
            endcase
        end
        // hardware clear first, then events, so an event always survives
        bank_d.pend = (bank_d.pend & ~hw_clr) | src_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_PEND: reg_rdata = bank_q.pend;
            SEL_EN:   reg_rdata = bank_q.en;
            SEL_PRIO: reg_rdata = bank_q.prio;
            default:  reg_rdata = ctrl_cur;
        endcase
    end

    assign pend = bank_q.pend;
    assign en   = bank_q.en;
    assign prio = bank_q.prio;
    assign gen  = bank_q.gen;
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
    parameter int                N_SRC       = 8,
    parameter int                VEC_W       = 16,
    parameter logic [VEC_W-1:0]  VEC_BASE    = 16'h0003,
    parameter int                VEC_STEP    = 8,
    parameter logic [N_SRC-1:0]  HW_CLR_MASK = 8'h05,
    parameter int                GEN_BIT     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [1:0]       reg_op,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    input  logic             cpu_insn_done,
    input  logic             cpu_reti,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic             irq_pend
);
    localparam int IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [VEC_W-1:0] STEP = VEC_W'(VEC_STEP);

    typedef struct packed {
        logic          req;
        logic [IW-1:0] idx;
        logic          lvl_hi;
        logic          act_hi;
        logic          act_lo;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [N_SRC-1:0] pend, en, prio, hw_clr, elig, hi_cand, lo_cand;
    logic             gen, hi_any, lo_any, take_hi, take_lo;
    logic [IW-1:0]    hi_idx, lo_idx;
    logic             act_hi, act_lo;

    intc_regbank #(.N(N_SRC), .GEN_BIT(GEN_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_op(reg_op),
        .reg_wdata(reg_wdata), .hw_clr(hw_clr), .reg_rdata(reg_rdata),
        .pend(pend), .en(en), .prio(prio), .gen(gen)
    );

    assign elig    = pend & en & {N_SRC{gen}};
    assign hi_cand = elig & prio;
    assign lo_cand = elig & ~prio;

    intc_pick #(.N(N_SRC), .IW(IW)) u_pick_hi (.req(hi_cand), .any(hi_any), .idx(hi_idx));
    intc_pick #(.N(N_SRC), .IW(IW)) u_pick_lo (.req(lo_cand), .any(lo_any), .idx(lo_idx));

    always_comb begin
        take_hi  = hi_any && !ctl_q.act_hi;
        take_lo  = !take_hi && lo_any && !ctl_q.act_hi && !ctl_q.act_lo;
        irq_pend = take_hi || take_lo;

        ctl_d  = ctl_q;
        hw_clr = '0;

        if (cpu_reti) begin
            if (ctl_q.act_hi) ctl_d.act_hi = 1'b0;
            else              ctl_d.act_lo = 1'b0;
        end

        if (ctl_q.req && irq_ack) begin
            ctl_d.req = 1'b0;
            if (ctl_q.lvl_hi) ctl_d.act_hi = 1'b1;
            else              ctl_d.act_lo = 1'b1;
            hw_clr[ctl_q.idx] = HW_CLR_MASK[ctl_q.idx];
        end else if (!ctl_q.req && cpu_insn_done && !cpu_reti && irq_pend) begin
            ctl_d.req    = 1'b1;
            ctl_d.lvl_hi = take_hi;
            ctl_d.idx    = take_hi ? hi_idx : lo_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign irq_req = ctl_q.req;
    assign irq_vec = VEC_BASE + STEP * VEC_W'(ctl_q.idx);
    assign act_hi  = ctl_q.act_hi;
    assign act_lo  = ctl_q.act_lo;
endmodule

// File: rtl/intc_two_level_chk.sv
module intc_two_level_chk #(
    parameter int N_SRC = 8,
    parameter int VEC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] src_evt,
    input logic [N_SRC-1:0] pend,
    input logic             gen,
    input logic             cpu_insn_done,
    input logic             cpu_reti,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             irq_pend,
    input logic             act_hi,
    input logic             act_lo
);
    // R1 R12
    evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_evt) |=> ((pend & $past(src_evt)) == $past(src_evt)));

    // R4 R7
    boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> ($past(cpu_insn_done) && !$past(cpu_reti)));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

    // R9
    no_call_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |-> !act_hi);

    // R10
    reti_top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_reti && !irq_ack && act_hi) |=> (!act_hi && (act_lo == $past(act_lo))));

    // R2 R3
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen |-> !irq_pend);
endmodule

bind intc_two_level intc_two_level_chk #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .pend(pend), .gen(gen),
    .cpu_insn_done(cpu_insn_done), .cpu_reti(cpu_reti), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_pend(irq_pend),
    .act_hi(act_hi), .act_lo(act_lo)
);

// File: tb/intc_two_level_tb.sv
module intc_two_level_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_evt = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [1:0]  reg_op = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        cpu_insn_done = 1'b0;
    logic        cpu_reti = 1'b0;
    logic        irq_ack = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_pend;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intc_two_level u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_op(reg_op), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_insn_done(cpu_insn_done),
        .cpu_reti(cpu_reti), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .irq_pend(irq_pend)
    );

    // selects and operations as stated in R13
    localparam logic [1:0] PEND = 2'd0, EN = 2'd1, PRI = 2'd2, CTRL = 2'd3;
    localparam logic [1:0] WR = 2'd0, SETB = 2'd1, CLRB = 2'd2, NOP = 2'd3;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_do(input logic [1:0] sel, input logic [1:0] op, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_op = op; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic evt(input logic [7:0] m);
        @(negedge clk); src_evt = m;
        @(negedge clk); src_evt = '0;
    endtask

    task automatic insn();
        @(negedge clk); cpu_insn_done = 1'b1;
        @(negedge clk); cpu_insn_done = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic reti(input logic with_insn);
        @(negedge clk); cpu_reti = 1'b1; cpu_insn_done = with_insn;
        @(negedge clk); cpu_reti = 1'b0; cpu_insn_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(PEND, d); chk("R13 reset pend", 32'(d), 0);
        rd(EN, d);   chk("R13 reset en", 32'(d), 0);
        rd(CTRL, d); chk("R13 reset ctrl", 32'(d), 0);
        chk("R4 reset req", 32'(irq_req), 0);
    endtask

    task automatic t_latch_and_gate();
        logic [7:0] d;
        evt(8'h08);
        rd(PEND, d); chk("R1 flag latched while disabled", 32'(d), 32'h08);
        chk("R2 no pend without enables", 32'(irq_pend), 0);
        reg_do(EN, SETB, 8'h08);
        chk("R2 no pend without global", 32'(irq_pend), 0);
        reg_do(CTRL, SETB, 8'h80);
        chk("R3 pend after global on", 32'(irq_pend), 1);
        chk("R4 no req before boundary", 32'(irq_req), 0);
        insn();
        chk("R4 req at boundary", 32'(irq_req), 1);
        chk("R5 vector source 3", 32'(irq_vec), 32'h1B);
        ack();
        chk("R4 req drops after ack", 32'(irq_req), 0);
        rd(PEND, d); chk("R6 software-cleared flag stays", 32'(d), 32'h08);
        chk("R9 same low level blocked", 32'(irq_pend), 0);
        reg_do(PEND, CLRB, 8'h08);
        reti(1'b0);
        reg_do(EN, WR, 8'h00);
    endtask

    task automatic t_hw_clear();
        logic [7:0] d;
        reg_do(EN, WR, 8'h04);
        reg_do(PEND, SETB, 8'h04);
        chk("R8 software set raises pend", 32'(irq_pend), 1);
        insn();
        chk("R5 vector source 2", 32'(irq_vec), 32'h13);
        ack();
        rd(PEND, d); chk("R6 hardware-cleared flag", 32'(d), 0);
        reti(1'b0);
        reg_do(EN, WR, 8'h00);
    endtask

    task automatic t_nesting();
        logic [7:0] d;
        reg_do(EN, WR, 8'h52);
        reg_do(PRI, WR, 8'h00);
        reg_do(PEND, WR, 8'h50);
        insn();
        chk("R11 lowest index wins", 32'(irq_vec), 32'h23);
        ack();
        chk("R9 low does not preempt low", 32'(irq_pend), 0);
        reg_do(PRI, WR, 8'h40);
        chk("R9 high may preempt low", 32'(irq_pend), 1);
        insn();
        chk("R9 preempting vector", 32'(irq_vec), 32'h33);
        ack();
        chk("R9 high not preempted", 32'(irq_pend), 0);
        reti(1'b1);
        chk("R7 no req on return cycle boundary", 32'(irq_req), 0);
        chk("R7 pend right after return", 32'(irq_pend), 1);
        insn();
        chk("R7 req after next instruction", 32'(irq_req), 1);
        chk("R7 re-entered vector", 32'(irq_vec), 32'h33);
        ack();
        reg_do(PEND, CLRB, 8'h40);
        reti(1'b0);
        chk("R10 low level still active", 32'(irq_pend), 0);
        reti(1'b0);
        chk("R10 low level retired", 32'(irq_pend), 1);
        reg_do(PEND, WR, 8'h42);
        insn();
        chk("R11 high beats lower index", 32'(irq_vec), 32'h33);
        ack();
        reg_do(PEND, WR, 8'h00);
        reti(1'b0);
        reg_do(EN, WR, 8'h00);
        reg_do(PRI, WR, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        reg_do(PEND, WR, 8'h20);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = PEND; reg_op = CLRB; reg_wdata = 8'h20; src_evt = 8'h20;
        @(negedge clk);
        reg_wr = 1'b0; src_evt = '0;
        rd(PEND, d); chk("R12 event beats clear", 32'(d), 32'h20);
        reg_do(PEND, WR, 8'h00);
    endtask

    task automatic t_global_hold();
        logic [7:0] d;
        reg_do(CTRL, CLRB, 8'h80);
        reg_do(EN, WR, 8'h02);
        evt(8'h02);
        insn();
        chk("R3 no req while global off", 32'(irq_req), 0);
        rd(PEND, d); chk("R3 flag held while global off", 32'(d), 32'h02);
        reg_do(CTRL, SETB, 8'h80);
        insn();
        chk("R3 serviced after global on", 32'(irq_vec), 32'h0B);
        ack();
        reg_do(PEND, WR, 8'h00);
        reti(1'b0);
        reg_do(EN, WR, 8'h00);
    endtask

    task automatic t_reg_ops();
        logic [7:0] d;
        reg_do(EN, WR, 8'hA5);
        rd(EN, d); chk("R13 write", 32'(d), 32'hA5);
        reg_do(EN, SETB, 8'h02);
        rd(EN, d); chk("R13 set bits", 32'(d), 32'hA7);
        reg_do(EN, CLRB, 8'h81);
        rd(EN, d); chk("R13 clear bits", 32'(d), 32'h26);
        reg_do(EN, NOP, 8'hFF);
        rd(EN, d); chk("R13 op 3 ignored", 32'(d), 32'h26);
        rd(CTRL, d); chk("R13 control bit 7", 32'(d), 32'h80);
        reg_do(EN, WR, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch_and_gate();
        t_hw_clear();
        t_nesting();
        t_collision();
        t_global_hold();
        t_reg_ops();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule